// File: doc/BRIEF.md
# Byte-to-Word Disk Sector Window Bridge

This block joins an 8-bit host bus to a 16-bit disk drive register interface. It claims a 1 KiB host region. The lower 512 bytes form a sector window, and every byte address in that window lands on the drive's single 16-bit data register. Because of this, a block string-move can walk the host pointer across a whole sector while the drive sees only data-register cycles. At region offsets 512 to 527 sits a 16-byte window in which the eight-bit command and status registers are reached one byte at a time.

A byte latch turns two host byte accesses into one 16-bit drive transfer. An even-offset read fetches a whole word, hands the low byte to the host and keeps the high byte. The odd-offset read that follows is served from the latch. An even-offset write parks the low byte in the latch. The odd-offset write then sends the full word to the drive.

A configuration pin selects whether the region answers host memory cycles or host I/O cycles. In memory mode the region is at a fixed address set by a parameter. In I/O mode its base comes from a byte register that the host writes at a fixed memory address near the top of the boot ROM area.

Host requests use valid/ready. The host holds `host_valid` and its request fields steady until it sees `host_ready` high at a clock edge. Ready drops for the one cycle in which a drive strobe is active. Read results come back as a single-cycle `host_rvalid` pulse that the host cannot stall.

Top module: `ide_sector_bridge`

## Requirements
- R1: After reset all drive selects and strobes are high (inactive), `host_ready` is 1, `host_rvalid` is 0, the byte latch reads 0x00 and the base register reads BASE_RST (0x0C).
- R2: A read at an even sector-window offset drives exactly one `dev_rd_n` low cycle with `dev_cs0_n`=0, `dev_cs1_n`=1 and `dev_addr`=0. The host receives `dev_rdata[7:0]`, and `dev_rdata[15:8]` is kept in the latch.
- R3: A read at an odd sector-window offset returns the latch contents without any drive strobe.
- R4: A write at an even sector-window offset only loads the latch, with no drive strobe. A write at an odd offset drives one `dev_wr_n` low cycle with `dev_wdata` = {new byte, latched byte}, `dev_cs0_n`=0 and `dev_addr`=0.
- R5: Every offset 0 to 511 of the sector window targets the data register: `dev_addr` is 0 and only `dev_cs0_n` is asserted, whatever the offset.
- R6: A command-window access at offset 512+r (r in 0..15) drives `dev_addr`=r[2:0]. It selects `dev_cs0_n` when r[3]=0 and `dev_cs1_n` when r[3]=1. A read returns `dev_rdata[7:0]`, and a write drives `dev_wdata`={0x00, byte}.
- R7: With `cfg_use_io`=0 only memory cycles (`host_is_io`=0) decode the region. With `cfg_use_io`=1 only I/O cycles do.
- R8: A memory write to BASE_REG_ADDR stores `host_wdata[5:0]` as the I/O region base, so the region starts at I/O address base×1024. A memory read there returns {2'b00, base}. This register is decoded in both modes.
- R9: An access that hits neither window nor the base register asserts no select or strobe. If it is a read, it returns `host_rvalid`=1 with `host_rdata_oe`=0.
- R10: `host_ready` is 0 while a drive strobe is active. Each accepted read gives one `host_rvalid` pulse: one cycle after acceptance when served locally, two cycles after when a drive read is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_use_io | input | 1 | 1: region answers I/O cycles; 0: memory cycles |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Bridge accepts the request at this edge |
| host_is_io | input | 1 | Request is an I/O cycle (else memory) |
| host_is_wr | input | 1 | Request is a write (else read) |
| host_addr | input | 20 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rvalid | output | 1 | Read result pulse |
| host_rdata | output | 8 | Read result byte |
| host_rdata_oe | output | 1 | Bridge drives the host data bus for this result |
| dev_cs0_n | output | 1 | Drive command-block select, active low |
| dev_cs1_n | output | 1 | Drive control-block select, active low |
| dev_addr | output | 3 | Drive register address |
| dev_rd_n | output | 1 | Drive read strobe, active low |
| dev_wr_n | output | 1 | Drive write strobe, active low |
| dev_wdata | output | 16 | Drive write word |
| dev_rdata | input | 16 | Drive read word |

## Verification
Two things can land in one cycle. The latch can be loaded by a drive read that is ending, and at the same edge the host can present its next request, such as the odd-offset read that will use that latch. The bench issues back-to-back even/odd pairs at random offsets, each even read carrying a fresh random word. It judges the odd result against a model latch that the bench updates from the word it supplied. The second collision is between an odd write and the latch byte stored by the write just before it. Random mixes of sector and command-window traffic check every drive word against the bench's model.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;
  typedef enum logic {ST_IDLE, ST_STROBE} br_state_t;

  typedef struct packed {
    logic       sector;
    logic       tfile;
    logic       base;
    logic       odd;
    logic       tf_hi;
    logic [2:0] tf_reg;
  } br_dec_t;
endpackage

// File: rtl/ide_bridge_decode.sv
module ide_bridge_decode
  import ide_bridge_pkg::*;
#(
  parameter int HAW = 20,
  parameter int IO_AW = 16,
  parameter int REGION_W = 10,
  parameter logic [HAW-1:0] MEM_REGION = 20'hC8000,
  parameter logic [HAW-1:0] BASE_REG_ADDR = 20'hF7FFF,
  localparam int BASE_W = IO_AW - REGION_W
) (
  input  logic              cfg_use_io,
  input  logic              is_io,
  input  logic [HAW-1:0]    addr,
  input  logic [BASE_W-1:0] io_base,
  output br_dec_t           dec
);
  logic              in_region;
  logic [REGION_W-1:0] off;

  assign off = addr[REGION_W-1:0];

  always_comb begin
    if (cfg_use_io)
      in_region = is_io && (addr[IO_AW-1:REGION_W] == io_base);
    else
      in_region = !is_io && (addr[HAW-1:REGION_W] == MEM_REGION[HAW-1:REGION_W]);
  end

  always_comb begin
    dec        = '0;
    dec.sector = in_region && !off[REGION_W-1];
    dec.tfile  = in_region && off[REGION_W-1] && (off[REGION_W-2:4] == '0);
    dec.base   = !is_io && (addr == BASE_REG_ADDR);
    dec.odd    = addr[0];
    dec.tf_hi  = addr[3];
    dec.tf_reg = addr[2:0];
  end
endmodule

// File: rtl/ide_bridge_reg.sv
module ide_bridge_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= RST;
    else if (load) q <= d;
  end
endmodule

// File: rtl/ide_sector_bridge.sv
module ide_sector_bridge
  import ide_bridge_pkg::*;
#(
  parameter int HAW = 20,
  parameter int IO_AW = 16,
  parameter int REGION_W = 10,
  parameter logic [HAW-1:0] MEM_REGION = 20'hC8000,
  parameter logic [HAW-1:0] BASE_REG_ADDR = 20'hF7FFF,
  parameter logic [5:0] BASE_RST = 6'h0C
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_use_io,
  input  logic           host_valid,
  output logic           host_ready,
  input  logic           host_is_io,
  input  logic           host_is_wr,
  input  logic [19:0]    host_addr,
  input  logic [7:0]     host_wdata,
  output logic           host_rvalid,
  output logic [7:0]     host_rdata,
  output logic           host_rdata_oe,
  output logic           dev_cs0_n,
  output logic           dev_cs1_n,
  output logic [2:0]     dev_addr,
  output logic           dev_rd_n,
  output logic           dev_wr_n,
  output logic [15:0]    dev_wdata,
  input  logic [15:0]    dev_rdata
);
  localparam int BASE_W = IO_AW - REGION_W;

  br_state_t          state_q;
  br_dec_t            dec;
  logic [BASE_W-1:0]  base_q;
  logic [7:0]         latch_q;
  logic               accept, needs_dev, pend_sector_q;
  logic               latch_ld, base_ld;
  logic [7:0]         latch_d;

  ide_bridge_decode #(
    .HAW(HAW), .IO_AW(IO_AW), .REGION_W(REGION_W),
    .MEM_REGION(MEM_REGION), .BASE_REG_ADDR(BASE_REG_ADDR)
  ) i_dec (
    .cfg_use_io(cfg_use_io), .is_io(host_is_io), .addr(host_addr[HAW-1:0]),
    .io_base(base_q), .dec(dec)
  );

  assign host_ready = (state_q == ST_IDLE);
  assign accept     = host_valid && host_ready;
  assign needs_dev  = (dec.sector && (host_is_wr == dec.odd)) || dec.tfile;

  // Latch: even write parks low byte; ending sector read keeps high byte
  always_comb begin
    latch_ld = 1'b0;
    latch_d  = host_wdata;
    if (accept && dec.sector && host_is_wr && !dec.odd) begin
      latch_ld = 1'b1;
    end else if (state_q == ST_STROBE && !dev_rd_n && pend_sector_q) begin
      latch_ld = 1'b1;
      latch_d  = dev_rdata[15:8];
    end
  end

  assign base_ld = accept && dec.base && host_is_wr;

  ide_bridge_reg #(.W(8), .RST(8'h00)) i_latch (
    .clk(clk), .rst_n(rst_n), .load(latch_ld), .d(latch_d), .q(latch_q)
  );

  ide_bridge_reg #(.W(BASE_W), .RST(BASE_RST[BASE_W-1:0])) i_base (
    .clk(clk), .rst_n(rst_n), .load(base_ld), .d(host_wdata[BASE_W-1:0]), .q(base_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      dev_cs0_n     <= 1'b1;
      dev_cs1_n     <= 1'b1;
      dev_rd_n      <= 1'b1;
      dev_wr_n      <= 1'b1;
      dev_addr      <= '0;
      dev_wdata     <= '0;
      pend_sector_q <= 1'b0;
      host_rvalid   <= 1'b0;
      host_rdata    <= '0;
      host_rdata_oe <= 1'b0;
    end else if (state_q == ST_STROBE) begin
      state_q   <= ST_IDLE;
      dev_cs0_n <= 1'b1;
      dev_cs1_n <= 1'b1;
      dev_rd_n  <= 1'b1;
      dev_wr_n  <= 1'b1;
      dev_addr  <= '0;
      if (!dev_rd_n) begin
        host_rvalid   <= 1'b1;
        host_rdata_oe <= 1'b1;
        host_rdata    <= dev_rdata[7:0];
      end
    end else begin
      host_rvalid <= 1'b0;
      if (accept && needs_dev) begin
        state_q       <= ST_STROBE;
        pend_sector_q <= dec.sector;
        dev_cs0_n     <= !(dec.sector || !dec.tf_hi);
        dev_cs1_n     <= !(dec.tfile && dec.tf_hi);
        dev_addr      <= dec.sector ? 3'd0 : dec.tf_reg;
        dev_rd_n      <= host_is_wr;
        dev_wr_n      <= !host_is_wr;
        dev_wdata     <= dec.sector ? {host_wdata, latch_q} : {8'h00, host_wdata};
      end else if (accept && !host_is_wr) begin
        host_rvalid   <= 1'b1;
        host_rdata_oe <= dec.sector || dec.base;
        if (dec.sector)    host_rdata <= latch_q;
        else if (dec.base) host_rdata <= {{(8-BASE_W){1'b0}}, base_q};
        else               host_rdata <= 8'h00;
      end
    end
  end
endmodule

// File: rtl/ide_sector_bridge_chk.sv
module ide_sector_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic host_ready,
  input logic host_rvalid,
  input logic host_rdata_oe,
  input logic dev_cs0_n,
  input logic dev_cs1_n,
  input logic dev_rd_n,
  input logic dev_wr_n
);
  a_r10_not_ready_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_rd_n || !dev_wr_n) |-> !host_ready);

  a_r2_read_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rd_n |=> dev_rd_n);

  a_r4_write_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_wr_n |=> dev_wr_n);

  a_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!dev_cs0_n, !dev_cs1_n}));

  a_r9_select_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_cs0_n || !dev_cs1_n) |-> (dev_rd_n != dev_wr_n));

  a_r10_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rd_n |=> (host_rvalid && host_rdata_oe));
endmodule

bind ide_sector_bridge ide_sector_bridge_chk i_chk (
  .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .host_rvalid(host_rvalid),
  .host_rdata_oe(host_rdata_oe), .dev_cs0_n(dev_cs0_n), .dev_cs1_n(dev_cs1_n),
  .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n)
);

// File: tb/test_ide_sector_bridge.sv
module test_ide_sector_bridge;
  localparam logic [19:0] REGION = 20'hC8000;
  localparam logic [19:0] BASEA  = 20'hF7FFF;

  logic clk = 0, rst_n = 0, cfg_use_io = 0;
  logic host_valid = 0, host_is_io = 0, host_is_wr = 0;
  logic [19:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic host_ready, host_rvalid, host_rdata_oe;
  logic [7:0] host_rdata;
  logic dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n;
  logic [2:0] dev_addr;
  logic [15:0] dev_wdata;
  logic [15:0] dev_rdata = '0;

  int n_chk = 0, n_bad = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic ev_cs0, ev_cs1;
  logic [2:0] ev_addr;
  logic [15:0] ev_wdata;
  logic [7:0] m_latch;

  always #5 clk = ~clk;

  ide_sector_bridge i_ide_sector_bridge (.*);

  // drive-side monitor: records each strobe cycle at the edge that ends it
  always @(posedge clk) begin
    if (rst_n && (!dev_rd_n || !dev_wr_n)) begin
      if (!dev_rd_n) rd_cnt++;
      if (!dev_wr_n) wr_cnt++;
      ev_cs0 = dev_cs0_n; ev_cs1 = dev_cs1_n;
      ev_addr = dev_addr; ev_wdata = dev_wdata;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit io, input bit wr, input logic [19:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output logic oe, output int lat);
    @(negedge clk);
    host_valid = 1; host_is_io = io; host_is_wr = wr; host_addr = a; host_wdata = d;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 0;
    lat = 1; rd = 'x; oe = 0;
    if (!wr) begin
      while (!host_rvalid && lat < 5) begin @(negedge clk); lat++; end
      rd = host_rdata; oe = host_rdata_oe;
    end else begin
      @(negedge clk);
    end
  endtask

  function automatic logic [19:0] sec_addr(input logic [8:0] off);
    return REGION + {11'd0, off};
  endfunction

  // sector-window operation checked against the bench latch model
  task automatic sector_op(input bit wr, input logic [8:0] off, input logic [7:0] d);
    logic [7:0] r; logic oe; int lat; int rd0, wr0;
    logic [15:0] w;
    w = 16'($urandom);
    dev_rdata = w;
    rd0 = rd_cnt; wr0 = wr_cnt;
    access(0, wr, sec_addr(off), d, r, oe, lat);
    if (!wr && !off[0]) begin
      chk("R2", "even read byte", r, w[7:0]);
      chk("R2", "read strobes", rd_cnt - rd0, 1);
      chk("R5", "sel/addr", {ev_cs0, ev_cs1, ev_addr}, {1'b0, 1'b1, 3'd0});
      chk("R10", "device read latency", lat, 2);
      m_latch = w[15:8];
    end else if (!wr) begin
      chk("R3", "odd read byte", r, m_latch);
      chk("R3", "no strobe", rd_cnt - rd0, 0);
      chk("R10", "local read latency", lat, 1);
    end else if (!off[0]) begin
      chk("R4", "even write no strobe", wr_cnt - wr0, 0);
      m_latch = d;
    end else begin
      chk("R4", "odd write strobes", wr_cnt - wr0, 1);
      chk("R4", "odd write word", ev_wdata, {d, m_latch});
      chk("R5", "write sel/addr", {ev_cs0, ev_cs1, ev_addr}, {1'b0, 1'b1, 3'd0});
    end
  endtask

  task automatic tfile_op(input bit io, input logic [19:0] rbase, input bit wr, input logic [3:0] r, input logic [7:0] d);
    logic [7:0] rv; logic oe; int lat; int rd0, wr0;
    logic [15:0] w;
    w = 16'($urandom);
    dev_rdata = w;
    rd0 = rd_cnt; wr0 = wr_cnt;
    access(io, wr, rbase + 20'd512 + {16'd0, r}, d, rv, oe, lat);
    chk("R6", "sel/addr", {ev_cs0, ev_cs1, ev_addr}, {r[3], !r[3], r[2:0]});
    if (wr) begin
      chk("R6", "write strobes", wr_cnt - wr0, 1);
      chk("R6", "write word", ev_wdata, {8'h00, d});
    end else begin
      chk("R6", "read strobes", rd_cnt - rd0, 1);
      chk("R6", "read byte", rv, w[7:0]);
    end
  endtask

  task automatic miss_read(input bit io, input logic [19:0] a, input string req);
    logic [7:0] rv; logic oe; int lat; int rd0;
    rd0 = rd_cnt;
    access(io, 0, a, 8'h00, rv, oe, lat);
    chk(req, "miss no strobe", rd_cnt - rd0, 0);
    chk(req, "miss bus undriven", {lat[3:0], oe}, {4'd1, 1'b0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rv; logic oe; int lat;
    void'($urandom(32'd1234));
    m_latch = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "idle pins", {dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n, host_ready, host_rvalid}, 6'b111110);
    access(0, 0, BASEA, 8'h00, rv, oe, lat);
    chk("R1", "base default", {oe, rv}, {1'b1, 8'h0C});
    chk("R8", "base read latency", lat, 1);
    sector_op(0, 9'd1, 8'h00);             // R1 latch cleared to zero
    // directed pairs at window edges
    sector_op(0, 9'd0, 8'h00);   sector_op(0, 9'd1, 8'h00);
    sector_op(0, 9'd510, 8'h00); sector_op(0, 9'd511, 8'h00);
    sector_op(1, 9'd0, 8'hA5);   sector_op(1, 9'd1, 8'h5A);
    sector_op(1, 9'd510, 8'h11); sector_op(1, 9'd511, 8'hEE);
    for (int r = 0; r < 16; r++) tfile_op(0, REGION, r[0], 4'(r), 8'(r * 7 + 3));
    // R9 misses in memory mode
    miss_read(0, REGION + 20'd528, "R9");
    miss_read(0, REGION - 20'd1, "R9");
    miss_read(1, 20'h03000, "R7");         // I/O cycle ignored in memory mode
    // random mix
    for (int k = 0; k < 300; k++) begin
      int kind;
      kind = int'($urandom % 5);
      case (kind)
        0: begin
          logic [8:0] o;
          o = 9'($urandom) & 9'h1FE;
          sector_op(0, o, 8'h00); sector_op(0, o | 9'd1, 8'h00);
        end
        1: sector_op(0, 9'($urandom), 8'h00);
        2: sector_op(1, 9'($urandom), 8'($urandom));
        3: tfile_op(0, REGION, 1'b0, 4'($urandom), 8'h00);
        default: tfile_op(0, REGION, 1'b1, 4'($urandom), 8'($urandom));
      endcase
    end
    // I/O mode
    @(negedge clk); cfg_use_io = 1;
    miss_read(0, REGION + 20'd2, "R7");   // memory region ignored in I/O mode
    tfile_op(1, 20'h03000, 1'b0, 4'd7, 8'h00);
    access(0, 1, BASEA, 8'h05, rv, oe, lat);
    access(0, 0, BASEA, 8'h00, rv, oe, lat);
    chk("R8", "base readback", {oe, rv}, {1'b1, 8'h05});
    miss_read(1, 20'h03000 + 20'd512, "R8");   // old base no longer decodes
    tfile_op(1, 20'h01400, 1'b1, 4'd9, 8'h3C);
    tfile_op(1, 20'h01400, 1'b0, 4'd2, 8'h00);
    begin
      logic [15:0] w; int rd0;
      w = 16'hBEEF; dev_rdata = w; rd0 = rd_cnt;
      access(1, 0, 20'h01400 + 20'd64, 8'h00, rv, oe, lat);
      chk("R7", "io sector read", {rd_cnt - rd0, rv}, {32'd1, 8'hEF});
      access(1, 0, 20'h01400 + 20'd65, 8'h00, rv, oe, lat);
      chk("R7", "io odd read from latch", rv, 8'hBE);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule